// File: doc/BRIEF.md
# Address-Range Memory Mapper

This block turns each bus address issued by an emulation CPU, together with the storage class of the cycle, into the set of control attributes that govern that cycle. These are whether read data comes from emulation memory or from the target, whether the location is write protected, whether the emulator must acknowledge the cycle itself, how many wait states to insert, and which of the data, breakpoint and access-flag memories take part. The address space is cut into 4 KB blocks. A programmable attribute table holds one entry per block for every storage class, so the same address may behave differently for, say, program fetches and data accesses.

A second, finer table covers one aligned byte window. For single bytes inside that window it can replace the internal/external choice and the write protection taken from the coarse table. A host port with address, data and write enable loads both tables. Lookups are registered: attributes appear one clock after the address is presented. A write is forwarded to emulation memory only when that memory is allocated to the block and the location does not behave like a ROM. Read data comes from emulation memory only when the block is both allocated and marked internal.

Top module: `addr_region_mapper`

## Requirements
- R1: Reset clears both tables and the output registers. Afterwards every lookup returns the unmapped default: external, unprotected, no acknowledge, zero wait states and no memory enables.
- R2: `out_valid` is `cpu_valid` delayed by exactly one clock. While `out_valid` is low, every attribute output is zero.
- R3: A coarse entry is selected by index `{class, block}`, with the class in the upper bits. Each storage class keeps its own attributes for the same address.
- R4: The block number is `cpu_addr[15:12]`. Every byte of a 4 KB block receives identical coarse attributes.
- R5: The coarse entry bits are: [0] internal, [1] protect, [2] acknowledge, [3] flag memory, [4] data memory, [5] break memory, [10:6] wait-state count. Acknowledge, the three memory enables and the wait count pass unchanged to `ack_req`, `data_en`, `break_en`, `flag_en` and `wait_cnt`.
- R6: `int_sel` is high only when the effective internal bit and the data-memory bit are both set.
- R7: `wr_protect` reports the effective protect bit. `emu_wr_en` is high for a write to a block with data memory, unless the effective internal and protect bits are both set.
- R8: The fine window covers addresses 0x0100 to 0x01FF, with fine entry bits [0] internal, [1] protect and [2] override. When override is set, that entry's internal and protect bits replace the coarse ones for every class. All other attributes still come from the coarse table.
- R9: A fine entry whose override bit is clear has no effect on any output.
- R10: A host table write is seen by the next lookup, not by a lookup presented in the same clock. `host_sel` = 0 selects the coarse table and 1 selects the fine table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Address and class are valid this cycle |
| cpu_addr | input | 16 | Emulation CPU byte address |
| cpu_class | input | 2 | Storage class of the cycle |
| cpu_write | input | 1 | Cycle is a write |
| host_we | input | 1 | Host table write strobe |
| host_sel | input | 1 | 0 = coarse table, 1 = fine table |
| host_addr | input | 8 | Table index ({class, block} or byte offset) |
| host_wdata | input | 11 | Entry value |
| out_valid | output | 1 | Attributes below belong to last cycle's lookup |
| int_sel | output | 1 | CPU read data supplied from emulation memory |
| wr_protect | output | 1 | Effective write protection |
| ack_req | output | 1 | Emulator generates the cycle acknowledge |
| wait_cnt | output | 5 | Wait states to insert |
| data_en | output | 1 | Data emulation memory enable |
| break_en | output | 1 | Breakpoint memory enable |
| flag_en | output | 1 | Access-flag memory enable |
| emu_wr_en | output | 1 | Forward the write to emulation memory |

## Verification
The checker assumes that `cpu_valid` and `cpu_write` are known, 0 or 1, in every cycle after reset, because the output relations are expressed against their values one clock earlier. It also assumes that host writes never target an index outside the table. The bench drives every input on the falling edge. It keeps all control inputs at zero during reset and issues only in-range coarse indices and fine offsets, so these assumptions hold throughout the run.

// File: rtl/mapper_pkg.sv
package mapper_pkg;

   // attribute flags carried by one coarse table entry (LSB first in storage)
   typedef struct packed {
      logic brk_map;
      logic data_map;
      logic flag_map;
      logic ack;
      logic protect;
      logic intern;
   } attr_flags_t;

   localparam int FLAG_BITS = $bits(attr_flags_t);

   // fine entry bit positions
   localparam int FINE_INTERN_BIT   = 0;
   localparam int FINE_PROTECT_BIT  = 1;
   localparam int FINE_OVERRIDE_BIT = 2;
   localparam int FINE_ENT_W        = 3;

endpackage

// File: rtl/coarse_attr_table.sv
module coarse_attr_table
   import mapper_pkg::*;
#(
   parameter int BLK_W   = 4,
   parameter int CLS_W   = 2,
   parameter int NUM_CLS = 4,
   parameter int WAIT_W  = 5,
   localparam int IDX_W  = CLS_W + BLK_W,
   localparam int ENT_W  = FLAG_BITS + WAIT_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [IDX_W-1:0]   wr_idx,
   input  logic [ENT_W-1:0]   wr_data,
   input  logic [CLS_W-1:0]   rd_class,
   input  logic [BLK_W-1:0]   rd_block,
   output attr_flags_t        rd_flags,
   output logic [WAIT_W-1:0]  rd_wait
);

   localparam int ENTRIES = NUM_CLS * (2 ** BLK_W);

   logic [ENT_W-1:0] tbl [ENTRIES];
   logic [IDX_W-1:0] rd_idx;
   logic [ENT_W-1:0] rd_ent;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < ENTRIES; i++) tbl[i] <= '0;
      end else if (wr_en && (int'(wr_idx) < ENTRIES)) begin
         tbl[wr_idx] <= wr_data;
      end
   end

   assign rd_idx = {rd_class, rd_block};

   always_comb begin
      if (int'(rd_idx) < ENTRIES) rd_ent = tbl[rd_idx];
      else                        rd_ent = '0;
   end

   assign rd_flags = attr_flags_t'(rd_ent[FLAG_BITS-1:0]);
   assign rd_wait  = rd_ent[ENT_W-1:FLAG_BITS];

endmodule

// File: rtl/fine_attr_table.sv
module fine_attr_table
   import mapper_pkg::*;
#(
   parameter int                ADDR_W    = 16,
   parameter int                FINE_W    = 8,
   parameter logic [ADDR_W-1:0] FINE_BASE = 16'h0100
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [FINE_W-1:0]     wr_idx,
   input  logic [FINE_ENT_W-1:0] wr_data,
   input  logic [ADDR_W-1:0]     rd_addr,
   output logic                  hit,
   output logic                  intern,
   output logic                  protect
);

   localparam int DEPTH = 2 ** FINE_W;

   logic [FINE_ENT_W-1:0] tbl [DEPTH];
   logic [FINE_ENT_W-1:0] ent;
   logic                  in_window;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) tbl[i] <= '0;
      end else if (wr_en) begin
         tbl[wr_idx] <= wr_data;
      end
   end

   assign in_window = (rd_addr[ADDR_W-1:FINE_W] == FINE_BASE[ADDR_W-1:FINE_W]);
   assign ent       = tbl[rd_addr[FINE_W-1:0]];
   assign hit       = in_window && ent[FINE_OVERRIDE_BIT];
   assign intern    = ent[FINE_INTERN_BIT];
   assign protect   = ent[FINE_PROTECT_BIT];

endmodule

// File: rtl/attr_resolve.sv
module attr_resolve
   import mapper_pkg::*;
#(
   parameter int WAIT_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lk_valid,
   input  logic              lk_write,
   input  attr_flags_t       c_flags,
   input  logic [WAIT_W-1:0] c_wait,
   input  logic              f_hit,
   input  logic              f_intern,
   input  logic              f_protect,
   output logic              out_valid,
   output logic              int_sel,
   output logic              wr_protect,
   output logic              ack_req,
   output logic [WAIT_W-1:0] wait_cnt,
   output logic              data_en,
   output logic              break_en,
   output logic              flag_en,
   output logic              emu_wr_en
);

   logic eff_intern, eff_protect, rom_like;

   assign eff_intern  = f_hit ? f_intern  : c_flags.intern;
   assign eff_protect = f_hit ? f_protect : c_flags.protect;
   assign rom_like    = eff_intern && eff_protect;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         int_sel    <= 1'b0;
         wr_protect <= 1'b0;
         ack_req    <= 1'b0;
         wait_cnt   <= '0;
         data_en    <= 1'b0;
         break_en   <= 1'b0;
         flag_en    <= 1'b0;
         emu_wr_en  <= 1'b0;
      end else begin
         out_valid  <= lk_valid;
         int_sel    <= lk_valid && eff_intern && c_flags.data_map;
         wr_protect <= lk_valid && eff_protect;
         ack_req    <= lk_valid && c_flags.ack;
         wait_cnt   <= lk_valid ? c_wait : '0;
         data_en    <= lk_valid && c_flags.data_map;
         break_en   <= lk_valid && c_flags.brk_map;
         flag_en    <= lk_valid && c_flags.flag_map;
         emu_wr_en  <= lk_valid && lk_write && c_flags.data_map && !rom_like;
      end
   end

endmodule

// File: rtl/addr_region_mapper.sv
module addr_region_mapper
   import mapper_pkg::*;
#(
   parameter int                ADDR_W      = 16,
   parameter int                BLOCK_BITS  = 12,
   parameter int                NUM_CLASSES = 4,
   parameter int                WAIT_W      = 5,
   parameter bit                FINE_EN     = 1'b1,
   parameter int                FINE_W      = 8,
   parameter logic [ADDR_W-1:0] FINE_BASE   = 16'h0100,
   localparam int CLS_W = $clog2(NUM_CLASSES),
   localparam int BLK_W = ADDR_W - BLOCK_BITS,
   localparam int IDX_W = CLS_W + BLK_W,
   localparam int HA_W  = (IDX_W > FINE_W) ? IDX_W : FINE_W,
   localparam int HD_W  = FLAG_BITS + WAIT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_valid,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [CLS_W-1:0]  cpu_class,
   input  logic              cpu_write,
   input  logic              host_we,
   input  logic              host_sel,
   input  logic [HA_W-1:0]   host_addr,
   input  logic [HD_W-1:0]   host_wdata,
   output logic              out_valid,
   output logic              int_sel,
   output logic              wr_protect,
   output logic              ack_req,
   output logic [WAIT_W-1:0] wait_cnt,
   output logic              data_en,
   output logic              break_en,
   output logic              flag_en,
   output logic              emu_wr_en
);

   // elaboration-time parameter checks
   if (NUM_CLASSES < 2)            begin : g_chk_cls  $error("NUM_CLASSES must be at least 2"); end
   if (BLOCK_BITS >= ADDR_W)       begin : g_chk_blk  $error("BLOCK_BITS must be below ADDR_W"); end
   if (WAIT_W < 1)                 begin : g_chk_wait $error("WAIT_W must be positive"); end
   if (FINE_EN && FINE_W > BLOCK_BITS) begin : g_chk_fine $error("fine window must fit in one block"); end

   attr_flags_t       c_flags;
   logic [WAIT_W-1:0] c_wait;
   logic              f_hit, f_intern, f_protect;

   coarse_attr_table #(
      .BLK_W   (BLK_W),
      .CLS_W   (CLS_W),
      .NUM_CLS (NUM_CLASSES),
      .WAIT_W  (WAIT_W)
   ) i_coarse (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (host_we && !host_sel),
      .wr_idx   (host_addr[IDX_W-1:0]),
      .wr_data  (host_wdata),
      .rd_class (cpu_class),
      .rd_block (cpu_addr[ADDR_W-1:BLOCK_BITS]),
      .rd_flags (c_flags),
      .rd_wait  (c_wait)
   );

   if (FINE_EN) begin : g_fine
      fine_attr_table #(
         .ADDR_W    (ADDR_W),
         .FINE_W    (FINE_W),
         .FINE_BASE (FINE_BASE)
      ) i_fine (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (host_we && host_sel),
         .wr_idx  (host_addr[FINE_W-1:0]),
         .wr_data (host_wdata[FINE_ENT_W-1:0]),
         .rd_addr (cpu_addr),
         .hit     (f_hit),
         .intern  (f_intern),
         .protect (f_protect)
      );
   end else begin : g_no_fine
      assign f_hit     = 1'b0;
      assign f_intern  = 1'b0;
      assign f_protect = 1'b0;
   end

   attr_resolve #(.WAIT_W(WAIT_W)) i_resolve (
      .clk        (clk),
      .rst_n      (rst_n),
      .lk_valid   (cpu_valid),
      .lk_write   (cpu_write),
      .c_flags    (c_flags),
      .c_wait     (c_wait),
      .f_hit      (f_hit),
      .f_intern   (f_intern),
      .f_protect  (f_protect),
      .out_valid  (out_valid),
      .int_sel    (int_sel),
      .wr_protect (wr_protect),
      .ack_req    (ack_req),
      .wait_cnt   (wait_cnt),
      .data_en    (data_en),
      .break_en   (break_en),
      .flag_en    (flag_en),
      .emu_wr_en  (emu_wr_en)
   );

endmodule

// File: rtl/mapper_checker.sv
module mapper_checker #(
   parameter int WAIT_W = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_valid,
   input logic              cpu_write,
   input logic              out_valid,
   input logic              int_sel,
   input logic              wr_protect,
   input logic              ack_req,
   input logic [WAIT_W-1:0] wait_cnt,
   input logic              data_en,
   input logic              break_en,
   input logic              flag_en,
   input logic              emu_wr_en
);

   assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_valid |=> out_valid);

   assert_idle_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_valid |=> !out_valid);

   assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> (wait_cnt == '0) && !int_sel && !wr_protect && !ack_req
                     && !data_en && !break_en && !flag_en && !emu_wr_en);

   assert_int_needs_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
      int_sel |-> data_en);

   assert_no_rom_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      emu_wr_en |-> data_en && !(int_sel && wr_protect));

   assert_emu_write_from_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      emu_wr_en |-> $past(cpu_write) && $past(cpu_valid));

endmodule

bind addr_region_mapper mapper_checker #(.WAIT_W(WAIT_W)) i_mapper_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .cpu_valid  (cpu_valid),
   .cpu_write  (cpu_write),
   .out_valid  (out_valid),
   .int_sel    (int_sel),
   .wr_protect (wr_protect),
   .ack_req    (ack_req),
   .wait_cnt   (wait_cnt),
   .data_en    (data_en),
   .break_en   (break_en),
   .flag_en    (flag_en),
   .emu_wr_en  (emu_wr_en)
);

// File: tb/test_addr_region_mapper.sv
module test_addr_region_mapper;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cpu_valid, cpu_write, host_we, host_sel;
   logic [15:0] cpu_addr;
   logic [1:0]  cpu_class;
   logic [7:0]  host_addr;
   logic [10:0] host_wdata;
   logic        out_valid, int_sel, wr_protect, ack_req, data_en, break_en, flag_en, emu_wr_en;
   logic [4:0]  wait_cnt;

   int  n_tests = 0;
   int  n_fail  = 0;
   bit  done    = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   addr_region_mapper i_addr_region_mapper (
      .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_addr(cpu_addr),
      .cpu_class(cpu_class), .cpu_write(cpu_write), .host_we(host_we),
      .host_sel(host_sel), .host_addr(host_addr), .host_wdata(host_wdata),
      .out_valid(out_valid), .int_sel(int_sel), .wr_protect(wr_protect),
      .ack_req(ack_req), .wait_cnt(wait_cnt), .data_en(data_en),
      .break_en(break_en), .flag_en(flag_en), .emu_wr_en(emu_wr_en)
   );

   // vector: {class, addr, write, {int,prot,ack,data,brk,flag,emu}, wait}
   localparam int NV = 13;
   localparam logic [30:0] VEC [NV] = '{
      {2'd0, 16'h0000, 1'b0, 7'b1011100, 5'd4},   // R5 R6
      {2'd0, 16'h0FFF, 1'b1, 7'b1011101, 5'd4},   // R4 R7
      {2'd1, 16'h0000, 1'b0, 7'b0001010, 5'd2},   // R3
      {2'd1, 16'h0800, 1'b1, 7'b0001011, 5'd2},   // R3 R7
      {2'd0, 16'h1000, 1'b1, 7'b1101000, 5'd0},   // R7 rom-like
      {2'd0, 16'h1FFF, 1'b0, 7'b1101000, 5'd0},   // R4
      {2'd0, 16'hF123, 1'b0, 7'b0010000, 5'd30},  // R5
      {2'd2, 16'h0000, 1'b0, 7'b0000000, 5'd0},   // R3 unmapped class
      {2'd0, 16'h2000, 1'b1, 7'b0000000, 5'd0},   // R4 unmapped block
      {2'd0, 16'h0110, 1'b1, 7'b0111101, 5'd4},   // R8
      {2'd0, 16'h0120, 1'b1, 7'b1011101, 5'd4},   // R9
      {2'd1, 16'h0110, 1'b0, 7'b0101010, 5'd2},   // R8 other class
      {2'd3, 16'hF000, 1'b1, 7'b0000000, 5'd0}    // R3
   };

   function automatic string vec_req(int i);
      case (i)
         0: return "R5";  1: return "R4"; 2: return "R3"; 3: return "R7";
         4: return "R7";  5: return "R4"; 6: return "R5"; 7: return "R3";
         8: return "R4";  9: return "R8"; 10: return "R9"; 11: return "R8";
         default: return "R3";
      endcase
   endfunction

   function automatic logic [11:0] outs();
      return {int_sel, wr_protect, ack_req, data_en, break_en, flag_en, emu_wr_en, wait_cnt};
   endfunction

   task automatic check(string req, logic [12:0] act, logic [12:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic host_wr(logic sel, logic [7:0] a, logic [10:0] d);
      @(negedge clk);
      host_we = 1'b1; host_sel = sel; host_addr = a; host_wdata = d;
      @(negedge clk);
      host_we = 1'b0;
   endtask

   // present one lookup, sample result one clock later (after the output register)
   task automatic lookup(logic [1:0] c, logic [15:0] a, logic w);
      @(negedge clk);
      cpu_valid = 1'b1; cpu_class = c; cpu_addr = a; cpu_write = w;
      @(negedge clk);
      cpu_valid = 1'b0; cpu_write = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; cpu_valid = 1'b0; cpu_write = 1'b0; host_we = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      rst_n = 1'b0; cpu_valid = 1'b0; cpu_write = 1'b0; cpu_addr = '0; cpu_class = '0;
      host_we = 1'b0; host_sel = 1'b0; host_addr = '0; host_wdata = '0;
      repeat (3) @(negedge clk);
      check("R1", {out_valid, outs()}, 13'h0);
      rst_n = 1'b1;

      // R1: lookup right after reset gives unmapped defaults
      lookup(2'd0, 16'h0000, 1'b1);
      check("R1", {out_valid, outs()}, {1'b1, 12'h0});

      // table setup: coarse index {class, block}, fine index = byte offset
      host_wr(1'b0, 8'h00, 11'h135);  // class0 block0
      host_wr(1'b0, 8'h10, 11'h098);  // class1 block0
      host_wr(1'b0, 8'h01, 11'h013);  // class0 block1
      host_wr(1'b0, 8'h0F, 11'h784);  // class0 block15
      host_wr(1'b1, 8'h10, 11'h006);  // fine 0x0110: override, protect
      host_wr(1'b1, 8'h20, 11'h002);  // fine 0x0120: no override

      for (int i = 0; i < NV; i++) begin
         lookup(VEC[i][30:29], VEC[i][28:13], VEC[i][12]);
         check(vec_req(i), {out_valid, outs()}, {1'b1, VEC[i][11:0]});
      end

      // R2: out_valid drops one clock after cpu_valid drops, outputs zero
      @(negedge clk);
      check("R2", {out_valid, outs()}, 13'h0);

      // R10: write and lookup in the same clock see the old entry
      @(negedge clk);
      host_we = 1'b1; host_sel = 1'b0; host_addr = 8'h35; host_wdata = 11'h010;
      cpu_valid = 1'b1; cpu_class = 2'd3; cpu_addr = 16'h5000; cpu_write = 1'b0;
      @(negedge clk);
      host_we = 1'b0;
      check("R10", {out_valid, outs()}, {1'b1, 12'h0});
      @(negedge clk);
      cpu_valid = 1'b0;
      check("R10", {out_valid, outs()}, {1'b1, 7'b0001000, 5'd0});

      // R1: reset again clears the tables
      do_reset();
      lookup(2'd0, 16'h0000, 1'b0);
      check("R1", {out_valid, outs()}, {1'b1, 12'h0});
      lookup(2'd0, 16'h0110, 1'b1);
      check("R1", {out_valid, outs()}, {1'b1, 12'h0});

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule